// File: doc/BRIEF.md
# Tile-Based VGA Text and Bar Display

This block produces a 640x480 VGA picture from a pixel clock. The screen is treated as a grid of 8x8-pixel cells, 80 across and 60 down, counted from the top-left corner. Each cell shows one character. A screen map, computed from the cell position, chooses the character. A glyph generator then turns that character into eight 8-bit rows, and the pixel's position inside the cell picks one bit of one row. The background is white and glyph pixels are black unless their cell has a colour assigned. A few cells are variable: they show a decimal digit taken from external 4-bit inputs. These are three temperature digits in red, one range digit in green, and four reading digits in black.

A horizontal blue bar is drawn pixel by pixel across a band of rows. Its length is the integer part of the reading, formed from the reading's tens and ones digits. The lookup runs as a two-stage pipeline: screen map, then glyph. The sync outputs are delayed by the same two clocks, so colour and sync leave the block aligned.

The timing, the placement of the label rows, the bar band and the axis are all parameters. A small screen can therefore be built for fast sweeps.

Top module: `tile_text_display`

## Requirements
- R1: Each line lasts H_ACTIVE+H_FRONT+H_SYNC+H_BACK clocks (800 by default). The active-low `hsync_n` is 0 for exactly H_SYNC clocks, at horizontal positions H_ACTIVE+H_FRONT up to H_ACTIVE+H_FRONT+H_SYNC-1 (656 to 751 by default).
- R2: Each frame lasts V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines (525 by default). The active-low `vsync_n` is 0 on lines V_ACTIVE+V_FRONT up to V_ACTIVE+V_FRONT+V_SYNC-1 (490 and 491 by default). The line counter changes only at the end of a line.
- R3: The first pixel after reset is position (0,0). The outputs at each clock show the pixel whose position the counters held two clocks earlier, and sync is delayed by the same amount. On the first clock after reset release the outputs are `rgb`=000 with both syncs high.
- R4: Every pixel outside the visible area (x >= H_ACTIVE or y >= V_ACTIVE) has red=green=blue=0.
- R5: A pixel at (x,y) lies in cell column x/8 and cell row y/8. Glyph row r = y mod 8 and glyph column c = x mod 8 select bit 7-c of row r. A character's 3x5 pattern occupies rows 1..5 and columns 2..4. The pattern is a 15-bit code, read top row first, with bit 14 at the top-left. The codes are: digit 0..9 = 7B6F, 2C97, 73E7, 73CF, 5BC9, 79CF, 79EF, 7249, 7BEF, 7BCF (hex); letter T = 7492; letter R = 6BAD; dot = 0002; blank = 0000.
- R6: A visible pixel whose glyph bit is off, outside the bar band, is white (111).
- R7: On cell row LABEL_ROW, cell 0 shows T and cell 5 shows R. On cell row READ_ROW, cell 2 shows a dot. All three are drawn in black (000).
- R8: Cells 1, 2 and 3 of LABEL_ROW show `temp_hi`, `temp_mid` and `temp_lo`. Their on-pixels are red (100).
- R9: Cell 6 of LABEL_ROW shows `range_sel`. Its on-pixels are green (010).
- R10: Cells 0, 1, 3 and 4 of READ_ROW show `rd_tens`, `rd_ones`, `rd_tenths` and `rd_hundredths` in black.
- R11: A digit input above 9 makes its cell blank (all white).
- R12: On pixel rows BAR_Y0 to BAR_Y0+BAR_H-1, a visible pixel is blue (001) when AXIS_X < x < AXIS_X+L, and white otherwise. L = 10*tens+ones, where a tens or ones digit above 9 counts as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_hi | input | 4 | Temperature hundreds digit |
| temp_mid | input | 4 | Temperature tens digit |
| temp_lo | input | 4 | Temperature ones digit |
| range_sel | input | 4 | Range digit |
| rd_tens | input | 4 | Reading tens digit |
| rd_ones | input | 4 | Reading ones digit |
| rd_tenths | input | 4 | Reading tenths digit |
| rd_hundredths | input | 4 | Reading hundredths digit |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 1 | Red colour |
| green | output | 1 | Green colour |
| blue | output | 1 | Blue colour |

## Verification
On every cycle the assertions check the counter wrap, that the line counter holds within a line, that the hsync pulse has the correct width, and that both syncs are the raw counter decode delayed by exactly two clocks. They also check that the colour is black whenever the pixel two clocks earlier lay outside the visible area. The cell contents cannot be checked by a property: glyph shapes, the colours given by position, blank cells for out-of-range digits, and the bar length built from two decimal digits. Only the bench shows these, by sweeping every pixel of several whole frames of a small screen. Each frame uses a different digit pattern, including invalid digits, a zero bar, a short bar and a bar clipped at the screen edge.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;

  localparam int CELL_BITS = 3;

  localparam logic [3:0] CODE_BLANK = 4'd10;
  localparam logic [3:0] CODE_T     = 4'd11;
  localparam logic [3:0] CODE_R     = 4'd12;
  localparam logic [3:0] CODE_DOT   = 4'd13;

  typedef enum logic [1:0] {
    INK_BLACK = 2'd0,
    INK_RED   = 2'd1,
    INK_GREEN = 2'd2
  } ink_e;

  // State carried from the screen-map stage to the glyph stage
  typedef struct packed {
    logic [3:0] code;
    ink_e       ink;
    logic [2:0] grow;
    logic [2:0] gcol;
    logic       bar;
    logic       vis;
    logic       hs_n;
    logic       vs_n;
  } tap_t;

  // 3x5 pattern, top row first, bit 14 = top-left (R5)
  function automatic logic [14:0] font_bits(input logic [3:0] code);
    case (code)
      4'd0:    return 15'h7B6F;
      4'd1:    return 15'h2C97;
      4'd2:    return 15'h73E7;
      4'd3:    return 15'h73CF;
      4'd4:    return 15'h5BC9;
      4'd5:    return 15'h79CF;
      4'd6:    return 15'h79EF;
      4'd7:    return 15'h7249;
      4'd8:    return 15'h7BEF;
      4'd9:    return 15'h7BCF;
      CODE_T:  return 15'h7492;
      CODE_R:  return 15'h6BAD;
      CODE_DOT:return 15'h0002;
      default: return 15'h0000;
    endcase
  endfunction

  // Expand a 3x5 pattern into an 8-bit glyph row, pattern in bits 5:3
  function automatic logic [7:0] glyph_row(input logic [3:0] code,
                                           input logic [2:0] row);
    logic [14:0] f;
    logic [7:0]  r;
    f = font_bits(code);
    r = 8'h00;
    case (row)
      3'd1: r[5:3] = f[14:12];
      3'd2: r[5:3] = f[11:9];
      3'd3: r[5:3] = f[8:6];
      3'd4: r[5:3] = f[5:3];
      3'd5: r[5:3] = f[2:0];
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] digit_code(input logic [3:0] v);
    return (v > 4'd9) ? CODE_BLANK : v;
  endfunction

  // Integer part of the reading; invalid digits count as zero (R12)
  function automatic logic [6:0] reading_len(input logic [3:0] tens,
                                             input logic [3:0] ones);
    logic [6:0] t;
    logic [6:0] o;
    t = (tens > 4'd9) ? 7'd0 : {3'b000, tens};
    o = (ones > 4'd9) ? 7'd0 : {3'b000, ones};
    return (t << 3) + (t << 1) + o;
  endfunction

endpackage

// File: rtl/tdisp_timing.sv
module tdisp_timing #(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          hs_raw,
  output logic          vs_raw,
  output logic          vis_raw
);

  localparam int HS_START = H_ACTIVE + H_FRONT;
  localparam int HS_END   = HS_START + H_SYNC;
  localparam int VS_START = V_ACTIVE + V_FRONT;
  localparam int VS_END   = VS_START + V_SYNC;

  logic line_end;
  logic frame_end;

  assign line_end  = (hcnt == HW'(H_TOTAL - 1));
  assign frame_end = (vcnt == VW'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign hs_raw  = !((int'(hcnt) >= HS_START) && (int'(hcnt) < HS_END));
  assign vs_raw  = !((int'(vcnt) >= VS_START) && (int'(vcnt) < VS_END));
  assign vis_raw = (int'(hcnt) < H_ACTIVE) && (int'(vcnt) < V_ACTIVE);

endmodule

// File: rtl/tdisp_cellmap.sv
module tdisp_cellmap
  import tdisp_pkg::*;
#(
  parameter int HW        = 10,
  parameter int VW        = 10,
  parameter int LABEL_ROW = 2,
  parameter int READ_ROW  = 4,
  parameter int BAR_Y0    = 64,
  parameter int BAR_H     = 16,
  parameter int AXIS_X    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  logic          hs_raw,
  input  logic          vs_raw,
  input  logic          vis_raw,
  input  logic [3:0]    temp_hi,
  input  logic [3:0]    temp_mid,
  input  logic [3:0]    temp_lo,
  input  logic [3:0]    range_sel,
  input  logic [3:0]    rd_tens,
  input  logic [3:0]    rd_ones,
  input  logic [3:0]    rd_tenths,
  input  logic [3:0]    rd_hundredths,
  output tap_t          tap
);

  localparam int CW = HW - CELL_BITS;
  localparam int RW = VW - CELL_BITS;

  logic [CW-1:0] ccol;
  logic [RW-1:0] crow;
  logic [3:0]    code;
  ink_e          ink;
  logic [6:0]    bar_len;
  logic          bar_hit;

  assign ccol    = hcnt[HW-1:CELL_BITS];
  assign crow    = vcnt[VW-1:CELL_BITS];
  assign bar_len = reading_len(rd_tens, rd_ones);

  // Screen map: fixed labels and variable digit cells
  always_comb begin
    code = CODE_BLANK;
    ink  = INK_BLACK;
    if (int'(crow) == LABEL_ROW) begin
      case (int'(ccol))
        0: code = CODE_T;
        1: begin code = digit_code(temp_hi);   ink = INK_RED;   end
        2: begin code = digit_code(temp_mid);  ink = INK_RED;   end
        3: begin code = digit_code(temp_lo);   ink = INK_RED;   end
        5: code = CODE_R;
        6: begin code = digit_code(range_sel); ink = INK_GREEN; end
        default: code = CODE_BLANK;
      endcase
    end else if (int'(crow) == READ_ROW) begin
      case (int'(ccol))
        0: code = digit_code(rd_tens);
        1: code = digit_code(rd_ones);
        2: code = CODE_DOT;
        3: code = digit_code(rd_tenths);
        4: code = digit_code(rd_hundredths);
        default: code = CODE_BLANK;
      endcase
    end
  end

  // Bar band: strictly between the axis and axis plus length
  always_comb begin
    bar_hit = vis_raw
           && (int'(vcnt) >= BAR_Y0) && (int'(vcnt) < BAR_Y0 + BAR_H)
           && (int'(hcnt) > AXIS_X)
           && (int'(hcnt) < AXIS_X + int'(bar_len));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tap.code <= CODE_BLANK;
      tap.ink  <= INK_BLACK;
      tap.grow <= 3'd0;
      tap.gcol <= 3'd0;
      tap.bar  <= 1'b0;
      tap.vis  <= 1'b0;
      tap.hs_n <= 1'b1;
      tap.vs_n <= 1'b1;
    end else begin
      tap.code <= code;
      tap.ink  <= ink;
      tap.grow <= vcnt[CELL_BITS-1:0];
      tap.gcol <= hcnt[CELL_BITS-1:0];
      tap.bar  <= bar_hit;
      tap.vis  <= vis_raw;
      tap.hs_n <= hs_raw;
      tap.vs_n <= vs_raw;
    end
  end

endmodule

// File: rtl/tdisp_pixel.sv
module tdisp_pixel
  import tdisp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  tap_t tap,
  output logic hsync_n,
  output logic vsync_n,
  output logic red,
  output logic green,
  output logic blue
);

  logic [7:0] row_bits;
  logic       glyph_on;
  logic [2:0] rgb_next;

  assign row_bits = glyph_row(tap.code, tap.grow);
  assign glyph_on = row_bits[3'd7 - tap.gcol];

  always_comb begin
    if (!tap.vis) begin
      rgb_next = 3'b000;
    end else if (tap.bar) begin
      rgb_next = 3'b001;
    end else if (!glyph_on) begin
      rgb_next = 3'b111;
    end else begin
      case (tap.ink)
        INK_RED:   rgb_next = 3'b100;
        INK_GREEN: rgb_next = 3'b010;
        default:   rgb_next = 3'b000;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      {red, green, blue} <= 3'b000;
    end else begin
      hsync_n <= tap.hs_n;
      vsync_n <= tap.vs_n;
      {red, green, blue} <= rgb_next;
    end
  end

endmodule

// File: rtl/tile_text_display.sv
module tile_text_display
  import tdisp_pkg::*;
#(
  parameter int H_ACTIVE  = 640,
  parameter int H_FRONT   = 16,
  parameter int H_SYNC    = 96,
  parameter int H_BACK    = 48,
  parameter int V_ACTIVE  = 480,
  parameter int V_FRONT   = 10,
  parameter int V_SYNC    = 2,
  parameter int V_BACK    = 33,
  parameter int LABEL_ROW = 2,
  parameter int READ_ROW  = 4,
  parameter int BAR_Y0    = 64,
  parameter int BAR_H     = 16,
  parameter int AXIS_X    = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] temp_hi,
  input  logic [3:0] temp_mid,
  input  logic [3:0] temp_lo,
  input  logic [3:0] range_sel,
  input  logic [3:0] rd_tens,
  input  logic [3:0] rd_ones,
  input  logic [3:0] rd_tenths,
  input  logic [3:0] rd_hundredths,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic       red,
  output logic       green,
  output logic       blue
);

  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);

  // Named internal events, observed by the bound checker
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          hs_raw;
  logic          vs_raw;
  logic          vis_raw;
  tap_t          tap;

  tdisp_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
  ) u_timing (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
    .hs_raw(hs_raw), .vs_raw(vs_raw), .vis_raw(vis_raw)
  );

  tdisp_cellmap #(
    .HW(HW), .VW(VW), .LABEL_ROW(LABEL_ROW), .READ_ROW(READ_ROW),
    .BAR_Y0(BAR_Y0), .BAR_H(BAR_H), .AXIS_X(AXIS_X)
  ) u_map (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
    .hs_raw(hs_raw), .vs_raw(vs_raw), .vis_raw(vis_raw),
    .temp_hi(temp_hi), .temp_mid(temp_mid), .temp_lo(temp_lo),
    .range_sel(range_sel), .rd_tens(rd_tens), .rd_ones(rd_ones),
    .rd_tenths(rd_tenths), .rd_hundredths(rd_hundredths),
    .tap(tap)
  );

  tdisp_pixel u_pix (
    .clk(clk), .rst(rst), .tap(tap),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .red(red), .green(green), .blue(blue)
  );

endmodule

// File: rtl/tdisp_checker.sv
module tdisp_checker #(
  parameter int HW      = 10,
  parameter int VW      = 10,
  parameter int H_TOTAL = 800,
  parameter int H_SYNC  = 96,
  localparam int RUNW   = $clog2(H_TOTAL + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt,
  input logic          hs_raw,
  input logic          vs_raw,
  input logic          vis_raw,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          red,
  input logic          green,
  input logic          blue
);

  logic [RUNW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)           low_run <= '0;
    else if (!hsync_n) low_run <= low_run + 1'b1;
    else               low_run <= '0;
  end

  assert_hcnt_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (hcnt == HW'(H_TOTAL - 1)) |=> (hcnt == '0));

  assert_hcnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    (vis_raw || !vis_raw) |-> (int'(hcnt) < H_TOTAL));

  assert_hsync_width_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_n) |-> (int'(low_run) == H_SYNC));

  assert_vcnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (hcnt != HW'(H_TOTAL - 1)) |=> $stable(vcnt));

  assert_sync_delay_R3: assert property (@(posedge clk) disable iff (rst)
    (hsync_n == $past(hs_raw, 2)) && (vsync_n == $past(vs_raw, 2)));

  assert_blank_outside_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(vis_raw, 2) |-> ({red, green, blue} == 3'b000));

endmodule

bind tile_text_display tdisp_checker #(
  .HW(HW), .VW(VW), .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC)
) u_chk (
  .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
  .hs_raw(hs_raw), .vs_raw(vs_raw), .vis_raw(vis_raw),
  .hsync_n(hsync_n), .vsync_n(vsync_n),
  .red(red), .green(green), .blue(blue)
);

// File: tb/sim_tile_text_display.sv
module sim_tile_text_display;

  localparam int HA = 64, HF = 4, HS = 8, HB = 4;
  localparam int VA = 32, VF = 2, VS = 2, VB = 2;
  localparam int LR = 0, RR = 1, BY0 = 20, BH = 6, AX = 4;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FT = HT * VT;
  localparam int NF = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] t_hi, t_mid, t_lo, rng, r_tens, r_ones, r_tenths, r_hund;
  logic hsync_n, vsync_n, red, green, blue;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tile_text_display #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .LABEL_ROW(LR), .READ_ROW(RR), .BAR_Y0(BY0), .BAR_H(BH), .AXIS_X(AX)
  ) u0 (
    .clk(clk), .rst(rst),
    .temp_hi(t_hi), .temp_mid(t_mid), .temp_lo(t_lo), .range_sel(rng),
    .rd_tens(r_tens), .rd_ones(r_ones), .rd_tenths(r_tenths),
    .rd_hundredths(r_hund),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .red(red), .green(green), .blue(blue)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_pattern(input int k);
    int p [8];
    case (k)
      0: p = '{1, 2, 3, 4, 0, 7, 5, 6};
      1: p = '{9, 8, 0, 1, 0, 0, 0, 0};
      2: p = '{4, 5, 6, 2, 9, 9, 9, 9};
      3: p = '{10, 15, 7, 12, 15, 3, 11, 2};
      4: p = '{0, 0, 0, 3, 5, 9, 1, 0};
      5: p = '{7, 6, 5, 9, 6, 0, 8, 8};
      default: p = '{2, 2, 2, 0, 1, 15, 3, 4};
    endcase
    t_hi = 4'(p[0]); t_mid = 4'(p[1]); t_lo = 4'(p[2]); rng = 4'(p[3]);
    r_tens = 4'(p[4]); r_ones = 4'(p[5]); r_tenths = 4'(p[6]); r_hund = 4'(p[7]);
  endtask

  // 3x5 patterns as listed in R5
  function automatic int font(input int code);
    case (code)
      0: return 'h7B6F;  1: return 'h2C97;  2: return 'h73E7;  3: return 'h73CF;
      4: return 'h5BC9;  5: return 'h79CF;  6: return 'h79EF;  7: return 'h7249;
      8: return 'h7BEF;  9: return 'h7BCF; 11: return 'h7492; 12: return 'h6BAD;
      13: return 'h0002;
      default: return 0;
    endcase
  endfunction

  function automatic int dval(input int v);
    return (v > 9) ? 0 : v;
  endfunction

  // Expected {r,g,b}: red=4, green=2, blue=1
  function automatic int exp_rgb(input int x, input int y, output string tag);
    int cx, cy, px, py, code, ink, raw, len;
    if (x >= HA || y >= VA) begin
      tag = "R4";
      return 0;
    end
    if (y >= BY0 && y < BY0 + BH) begin
      tag = "R12";
      len = dval(int'(r_tens)) * 10 + dval(int'(r_ones));
      return (x > AX && x < AX + len) ? 1 : 7;
    end
    cx = x / 8; cy = y / 8; px = x % 8; py = y % 8;
    code = 10; ink = 0; raw = -1; tag = "R6";
    if (cy == LR) begin
      case (cx)
        0: begin code = 11; tag = "R5/R7"; end
        1: begin raw = int'(t_hi);  ink = 4; tag = "R5/R8"; end
        2: begin raw = int'(t_mid); ink = 4; tag = "R5/R8"; end
        3: begin raw = int'(t_lo);  ink = 4; tag = "R5/R8"; end
        5: begin code = 12; tag = "R5/R7"; end
        6: begin raw = int'(rng);   ink = 2; tag = "R5/R9"; end
        default: ;
      endcase
    end else if (cy == RR) begin
      case (cx)
        0: begin raw = int'(r_tens);   tag = "R5/R10"; end
        1: begin raw = int'(r_ones);   tag = "R5/R10"; end
        2: begin code = 13; tag = "R5/R7"; end
        3: begin raw = int'(r_tenths); tag = "R5/R10"; end
        4: begin raw = int'(r_hund);   tag = "R5/R10"; end
        default: ;
      endcase
    end
    if (raw >= 0) begin
      if (raw > 9) begin code = 10; tag = "R11"; end
      else code = raw;
    end
    if (py >= 1 && py <= 5 && px >= 2 && px <= 4)
      if (((font(code) >> (14 - 3 * (py - 1) - (px - 2))) & 1) == 1)
        return ink;
    return 7;
  endfunction

  initial begin
    int idx, x, line, er, ar;
    string tag;
    set_pattern(0);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    for (int n = 1; n <= NF * FT + 1; n++) begin
      @(posedge clk);
      #1;
      ar = int'({red, green, blue});
      if (n == 1) begin
        // R3: reset state one clock after release
        chk(ar == 0, "R3 rgb", ar, 0);
        chk(hsync_n == 1'b1, "R3 hsync_n", int'(hsync_n), 1);
        chk(vsync_n == 1'b1, "R3 vsync_n", int'(vsync_n), 1);
      end else begin
        // R3: output shows the pixel the counters held two clocks earlier
        idx  = n - 2;
        x    = idx % HT;
        line = (idx / HT) % VT;
        chk(int'(hsync_n) == ((x >= HA + HF && x < HA + HF + HS) ? 0 : 1),
            "R1 hsync_n", int'(hsync_n), (x >= HA + HF && x < HA + HF + HS) ? 0 : 1);
        chk(int'(vsync_n) == ((line >= VA + VF && line < VA + VF + VS) ? 0 : 1),
            "R2 vsync_n", int'(vsync_n), (line >= VA + VF && line < VA + VF + VS) ? 0 : 1);
        er = exp_rgb(x, line, tag);
        chk(ar == er, tag, ar, er);
        if ((idx % FT) == FT - HT && (idx / FT) + 1 < NF)
          set_pattern((idx / FT) + 1);
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule